// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block sequences the pins of an asynchronous SRAM or NOR-flash style external bus on behalf of an internal requester. A request carries a read/write flag, a chip-select index, a word address, a bank address, byte enables and write data. It is accepted through a valid/ready handshake. Each access is then played out as three phases: address setup, strobe and hold. The length of each phase is a count of controller clock cycles, taken from timing fields that belong to the selected chip select. Reads and writes have separate fields.

Each chip select can also enable an extended-wait mode. In that mode an active-low wait input from the memory stretches the strobe. A select-strobe option makes the chip select follow the read or write strobe instead of framing the whole access. A programmable turnaround gap keeps the controller busy after each access. Read data is sampled from the bus and returned together with a one-cycle completion pulse.

Top module: `xmem_async_ctrl`

## Requirements
- R1: A read accepted at a clock edge runs setup for RS cycles, then strobe for RST cycles with `mem_oe_n` low, then hold for RH cycles. `rsp_done` is high in the last hold cycle, which is cycle RS+RST+RH after the accepting edge.
- R2: A write runs WS setup, WST strobe and WH hold cycles, with `mem_we_n` low for exactly WST cycles. For all WS+WST+WH cycles `mem_dq_oe` is 1 and `mem_dq_out` equals the request's write data.
- R3: During every cycle of an access, from the first setup cycle to the last hold cycle, the following stay constant: `mem_addr` equals the request address, `mem_bank` equals the request bank, and `mem_bmask_n` equals the bitwise inverse of the request byte enables. When no access is running, `mem_bmask_n` is all ones.
- R4: When the select-strobe bit of the chip select is 0, that chip select is low for the whole access (setup through hold). When the bit is 1, it is low only in the cycles where the read or write strobe is low.
- R5: A request index i (0 to NCS-1) drives only `mem_cs_n[i]` low. No other chip-select bit goes low, and no more than one bit is ever low.
- R6: A timing field of 0 acts as a count of 1.
- R7: Extended wait applies when the wait-enable bit of the chip select is 1 and the synchronized wait input is asserted in the last programmed strobe cycle. In that case the strobe stays low until the synchronized wait is seen released, and then stays low for 4 more cycles. The wait input goes through two flops. If `mem_wait_n` has been low since before the access and rises right after the K-th strobe-low cycle (K ≥ strobe count), the strobe is low for K+6 cycles in total. If the wait input is high, the strobe width is unchanged.
- R8: When the wait-enable bit is 0, `mem_wait_n` has no effect: the strobe width equals the programmed count.
- R9: `rsp_rdata` holds the value that `mem_dq_in` had in the last strobe-low cycle of a read. `rsp_done` is high for exactly one cycle per access.
- R10: After the cycle with `rsp_done`, `req_ready` stays low for TA cycles, where TA is the turnaround field of the chip select just used. With TA = 0, `req_ready` is high in the very next cycle.
- R11: `req_ready` is high only while idle, and an idle bus has every chip select, `mem_oe_n` and `mem_we_n` high. A `req_valid` pulse while `req_ready` is low starts no access.
- R12: `mem_oe_n` and `mem_we_n` are never low together, and `mem_dq_oe` is 0 throughout a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | IW | Chip-select index |
| req_addr | input | AW | Word address |
| req_bank | input | BW | Bank address |
| req_be | input | DW/8 | Byte enables, active high |
| req_wdata | input | DW | Write data |
| cfg_rd_setup | input | NCS*4 | Read setup count per chip select |
| cfg_rd_strobe | input | NCS*4 | Read strobe count per chip select |
| cfg_rd_hold | input | NCS*4 | Read hold count per chip select |
| cfg_wr_setup | input | NCS*4 | Write setup count per chip select |
| cfg_wr_strobe | input | NCS*4 | Write strobe count per chip select |
| cfg_wr_hold | input | NCS*4 | Write hold count per chip select |
| cfg_turn | input | NCS*4 | Turnaround count per chip select |
| cfg_ext_wait | input | NCS | Extended-wait enable per chip select |
| cfg_sel_strobe | input | NCS | Select-strobe mode per chip select |
| rsp_done | output | 1 | One-cycle access completion |
| rsp_rdata | output | DW | Captured read data |
| mem_cs_n | output | NCS | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | AW | External address |
| mem_bank | output | BW | External bank address |
| mem_bmask_n | output | DW/8 | Active-low byte masks |
| mem_dq_out | output | DW | Data bus drive value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DW | Data bus sampled value |
| mem_wait_n | input | 1 | Active-low wait from memory |

## Verification
The end of the programmed strobe count and the release of the wait input can fall in the same cycle. In that case the controller has to decide, on a synchronizer output that is just changing, whether to stretch the strobe, and it has to move the read-data capture point to match. The bench provokes this by holding the wait input low from before the access and releasing it right after the strobe-low cycle that the programmed count marks as last. It also runs a case where the release comes a few cycles later. Each case is judged on the measured strobe width (K+6) and on which cycle's data value is returned. A bus pattern that changes every cycle shows any capture that is off by one cycle.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int XM_CNT_W   = 4;
  localparam int XM_REL_CYC = 4;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_SETUP,
    XS_STROBE,
    XS_WAITX,
    XS_WREL,
    XS_HOLD,
    XS_TURN
  } xm_state_e;

  function automatic logic [XM_CNT_W-1:0] xm_min1(input logic [XM_CNT_W-1:0] v);
    return (v == '0) ? XM_CNT_W'(1) : v;
  endfunction
endpackage

// File: rtl/xmem_wait_sync.sv
module xmem_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_n_async,
  output logic waiting
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= '1;
    end else begin
      ff_q <= {ff_q[STAGES-2:0], wait_n_async};
    end
  end

  assign waiting = ~ff_q[STAGES-1];
endmodule

// File: rtl/xmem_timing_sel.sv
module xmem_timing_sel import xmem_pkg::*; #(
  parameter int NCS = 3,
  parameter int IW  = 2
) (
  input  logic [IW-1:0]           sel_idx,
  input  logic                    sel_wr,
  input  logic [NCS*XM_CNT_W-1:0] rd_setup,
  input  logic [NCS*XM_CNT_W-1:0] rd_strobe,
  input  logic [NCS*XM_CNT_W-1:0] rd_hold,
  input  logic [NCS*XM_CNT_W-1:0] wr_setup,
  input  logic [NCS*XM_CNT_W-1:0] wr_strobe,
  input  logic [NCS*XM_CNT_W-1:0] wr_hold,
  input  logic [NCS*XM_CNT_W-1:0] turn,
  input  logic [NCS-1:0]          ext_wait,
  input  logic [NCS-1:0]          sel_strobe,
  output logic [XM_CNT_W-1:0]     setup_len,
  output logic [XM_CNT_W-1:0]     strobe_len,
  output logic [XM_CNT_W-1:0]     hold_len,
  output logic [XM_CNT_W-1:0]     turn_len,
  output logic                    ew_en,
  output logic                    ss_en
);
  localparam int CW = XM_CNT_W;

  logic [CW-1:0] s_raw, st_raw, h_raw;

  always_comb begin
    s_raw    = '0;
    st_raw   = '0;
    h_raw    = '0;
    turn_len = '0;
    ew_en    = 1'b0;
    ss_en    = 1'b0;
    for (int i = 0; i < NCS; i++) begin
      if (sel_idx == IW'(i)) begin
        s_raw    = sel_wr ? wr_setup[i*CW +: CW]  : rd_setup[i*CW +: CW];
        st_raw   = sel_wr ? wr_strobe[i*CW +: CW] : rd_strobe[i*CW +: CW];
        h_raw    = sel_wr ? wr_hold[i*CW +: CW]   : rd_hold[i*CW +: CW];
        turn_len = turn[i*CW +: CW];
        ew_en    = ext_wait[i];
        ss_en    = sel_strobe[i];
      end
    end
  end

  assign setup_len  = xm_min1(s_raw);
  assign strobe_len = xm_min1(st_raw);
  assign hold_len   = xm_min1(h_raw);
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq import xmem_pkg::*; #(
  parameter int AW  = 22,
  parameter int DW  = 16,
  parameter int BW  = 2,
  parameter int MW  = 2,
  parameter int NCS = 3,
  parameter int IW  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [IW-1:0]       req_cs,
  input  logic [AW-1:0]       req_addr,
  input  logic [BW-1:0]       req_bank,
  input  logic [MW-1:0]       req_be,
  input  logic [DW-1:0]       req_wdata,
  input  logic [XM_CNT_W-1:0] setup_len,
  input  logic [XM_CNT_W-1:0] strobe_len,
  input  logic [XM_CNT_W-1:0] hold_len,
  input  logic [XM_CNT_W-1:0] turn_len,
  input  logic                ew_en,
  input  logic                ss_en,
  input  logic                waiting,
  output logic [IW-1:0]       cur_idx,
  output logic                cur_wr,
  output logic                rsp_done,
  output logic [DW-1:0]       rsp_rdata,
  output logic [NCS-1:0]      mem_cs_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [AW-1:0]       mem_addr,
  output logic [BW-1:0]       mem_bank,
  output logic [MW-1:0]       mem_bmask_n,
  output logic [DW-1:0]       mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DW-1:0]       mem_dq_in
);
  localparam int            CW       = XM_CNT_W;
  localparam logic [CW-1:0] REL_LAST = CW'(XM_REL_CYC - 1);

  xm_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          accept, capture;
  logic [IW-1:0] idx_q;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] bank_q;
  logic [MW-1:0] bmask_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          in_access, in_strobe, cs_window;

  assign req_ready = (state_q == XS_IDLE);
  assign accept    = req_valid && req_ready;

  // next-state and phase counter
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    capture = 1'b0;
    case (state_q)
      XS_IDLE: begin
        if (accept) begin
          state_d = XS_SETUP;
          cnt_d   = '0;
        end
      end
      XS_SETUP: begin
        if (cnt_q == setup_len - 1'b1) begin
          state_d = XS_STROBE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      XS_STROBE: begin
        if (cnt_q == strobe_len - 1'b1) begin
          cnt_d = '0;
          if (ew_en && waiting) begin
            state_d = XS_WAITX;
          end else begin
            state_d = XS_HOLD;
            capture = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      XS_WAITX: begin
        if (!waiting) begin
          state_d = XS_WREL;
          cnt_d   = '0;
        end
      end
      XS_WREL: begin
        if (cnt_q == REL_LAST) begin
          state_d = XS_HOLD;
          cnt_d   = '0;
          capture = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      XS_HOLD: begin
        if (cnt_q == hold_len - 1'b1) begin
          cnt_d   = '0;
          state_d = (turn_len != '0) ? XS_TURN : XS_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      XS_TURN: begin
        if (cnt_q == turn_len - 1'b1) begin
          state_d = XS_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = XS_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // request latch, enabled by the handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      bank_q  <= '0;
      bmask_q <= '1;
      wdata_q <= '0;
    end else if (accept) begin
      idx_q   <= req_cs;
      wr_q    <= req_write;
      addr_q  <= req_addr;
      bank_q  <= req_bank;
      bmask_q <= ~req_be;
      wdata_q <= req_wdata;
    end
  end

  // read data, enabled on the final strobe cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= mem_dq_in;
    end
  end

  assign in_strobe = (state_q == XS_STROBE) || (state_q == XS_WAITX) ||
                     (state_q == XS_WREL);
  assign in_access = in_strobe || (state_q == XS_SETUP) || (state_q == XS_HOLD);
  assign cs_window = ss_en ? in_strobe : in_access;

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign mem_cs_n[g] = ~(cs_window && (idx_q == IW'(g)));
  end

  assign mem_oe_n    = ~(in_strobe && !wr_q);
  assign mem_we_n    = ~(in_strobe && wr_q);
  assign mem_addr    = addr_q;
  assign mem_bank    = bank_q;
  assign mem_bmask_n = in_access ? bmask_q : '1;
  assign mem_dq_out  = wdata_q;
  assign mem_dq_oe   = in_access && wr_q;
  assign rsp_done    = (state_q == XS_HOLD) && (cnt_q == hold_len - 1'b1);
  assign rsp_rdata   = rdata_q;
  assign cur_idx     = idx_q;
  assign cur_wr      = wr_q;
endmodule

// File: rtl/xmem_async_ctrl.sv
module xmem_async_ctrl import xmem_pkg::*; #(
  parameter int AW  = 22,
  parameter int DW  = 16,
  parameter int BW  = 2,
  parameter int NCS = 3,
  localparam int IW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int MW = DW / 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [IW-1:0]           req_cs,
  input  logic [AW-1:0]           req_addr,
  input  logic [BW-1:0]           req_bank,
  input  logic [MW-1:0]           req_be,
  input  logic [DW-1:0]           req_wdata,
  input  logic [NCS*XM_CNT_W-1:0] cfg_rd_setup,
  input  logic [NCS*XM_CNT_W-1:0] cfg_rd_strobe,
  input  logic [NCS*XM_CNT_W-1:0] cfg_rd_hold,
  input  logic [NCS*XM_CNT_W-1:0] cfg_wr_setup,
  input  logic [NCS*XM_CNT_W-1:0] cfg_wr_strobe,
  input  logic [NCS*XM_CNT_W-1:0] cfg_wr_hold,
  input  logic [NCS*XM_CNT_W-1:0] cfg_turn,
  input  logic [NCS-1:0]          cfg_ext_wait,
  input  logic [NCS-1:0]          cfg_sel_strobe,
  output logic                    rsp_done,
  output logic [DW-1:0]           rsp_rdata,
  output logic [NCS-1:0]          mem_cs_n,
  output logic                    mem_oe_n,
  output logic                    mem_we_n,
  output logic [AW-1:0]           mem_addr,
  output logic [BW-1:0]           mem_bank,
  output logic [MW-1:0]           mem_bmask_n,
  output logic [DW-1:0]           mem_dq_out,
  output logic                    mem_dq_oe,
  input  logic [DW-1:0]           mem_dq_in,
  input  logic                    mem_wait_n
);
  logic [XM_CNT_W-1:0] setup_len, strobe_len, hold_len, turn_len;
  logic                ew_en, ss_en, waiting, cur_wr;
  logic [IW-1:0]       cur_idx;

  xmem_wait_sync #(.STAGES(2)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .wait_n_async (mem_wait_n),
    .waiting      (waiting)
  );

  xmem_timing_sel #(.NCS(NCS), .IW(IW)) u_tsel (
    .sel_idx    (cur_idx),
    .sel_wr     (cur_wr),
    .rd_setup   (cfg_rd_setup),
    .rd_strobe  (cfg_rd_strobe),
    .rd_hold    (cfg_rd_hold),
    .wr_setup   (cfg_wr_setup),
    .wr_strobe  (cfg_wr_strobe),
    .wr_hold    (cfg_wr_hold),
    .turn       (cfg_turn),
    .ext_wait   (cfg_ext_wait),
    .sel_strobe (cfg_sel_strobe),
    .setup_len  (setup_len),
    .strobe_len (strobe_len),
    .hold_len   (hold_len),
    .turn_len   (turn_len),
    .ew_en      (ew_en),
    .ss_en      (ss_en)
  );

  xmem_seq #(
    .AW(AW), .DW(DW), .BW(BW), .MW(MW), .NCS(NCS), .IW(IW)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_cs      (req_cs),
    .req_addr    (req_addr),
    .req_bank    (req_bank),
    .req_be      (req_be),
    .req_wdata   (req_wdata),
    .setup_len   (setup_len),
    .strobe_len  (strobe_len),
    .hold_len    (hold_len),
    .turn_len    (turn_len),
    .ew_en       (ew_en),
    .ss_en       (ss_en),
    .waiting     (waiting),
    .cur_idx     (cur_idx),
    .cur_wr      (cur_wr),
    .rsp_done    (rsp_done),
    .rsp_rdata   (rsp_rdata),
    .mem_cs_n    (mem_cs_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_addr    (mem_addr),
    .mem_bank    (mem_bank),
    .mem_bmask_n (mem_bmask_n),
    .mem_dq_out  (mem_dq_out),
    .mem_dq_oe   (mem_dq_oe),
    .mem_dq_in   (mem_dq_in)
  );
endmodule

// File: rtl/xmem_async_ctrl_chk.sv
module xmem_async_ctrl_chk #(
  parameter int NCS = 3,
  parameter int AW  = 22
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_ready,
  input logic           rsp_done,
  input logic [NCS-1:0] mem_cs_n,
  input logic           mem_oe_n,
  input logic           mem_we_n,
  input logic [AW-1:0]  mem_addr,
  input logic           mem_dq_oe
);
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R12

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R12

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_cs_n) <= 1); // R5

  AST_STROBE_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1)); // R4

  AST_WE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe); // R2

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n == '1 && mem_oe_n && mem_we_n)); // R11

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_cs_n != '1) && $past(mem_cs_n != '1)) |-> $stable(mem_addr)); // R3
endmodule

bind xmem_async_ctrl xmem_async_ctrl_chk #(.NCS(NCS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_addr  (mem_addr),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/xmem_async_ctrl_bench.sv
module xmem_async_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 22, DW = 16, BW = 2, NCS = 3, CW = 4, IW = 2, MW = 2;
  localparam int NV = 7;
  // {wr, cs[1:0], s, st, h, ta, ss, exp_total[5:0], exp_strobe[3:0], exp_cs[5:0]}
  localparam logic [35:0] VEC [0:NV-1] = '{
    {1'b0, 2'd0, 4'd2,  4'd3,  4'd1,  4'd2,  1'b0, 6'd6,  4'd3,  6'd6},
    {1'b1, 2'd1, 4'd1,  4'd2,  4'd3,  4'd0,  1'b0, 6'd6,  4'd2,  6'd6},
    {1'b0, 2'd2, 4'd3,  4'd1,  4'd2,  4'd1,  1'b1, 6'd6,  4'd1,  6'd1},
    {1'b1, 2'd2, 4'd2,  4'd4,  4'd2,  4'd3,  1'b1, 6'd8,  4'd4,  6'd4},
    {1'b0, 2'd0, 4'd0,  4'd0,  4'd0,  4'd0,  1'b0, 6'd3,  4'd1,  6'd3},
    {1'b1, 2'd1, 4'd0,  4'd5,  4'd0,  4'd1,  1'b0, 6'd7,  4'd5,  6'd7},
    {1'b0, 2'd1, 4'd15, 4'd15, 4'd15, 4'd15, 1'b0, 6'd45, 4'd15, 6'd45}
  };

  logic clk, rst_n;
  logic req_valid, req_ready, req_write;
  logic [IW-1:0] req_cs;
  logic [AW-1:0] req_addr;
  logic [BW-1:0] req_bank;
  logic [MW-1:0] req_be;
  logic [DW-1:0] req_wdata;
  logic [NCS*CW-1:0] cfg_rd_setup, cfg_rd_strobe, cfg_rd_hold;
  logic [NCS*CW-1:0] cfg_wr_setup, cfg_wr_strobe, cfg_wr_hold, cfg_turn;
  logic [NCS-1:0] cfg_ext_wait, cfg_sel_strobe;
  logic rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [NCS-1:0] mem_cs_n;
  logic mem_oe_n, mem_we_n, mem_dq_oe, mem_wait_n;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] mem_bank;
  logic [MW-1:0] mem_bmask_n;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  int n_tests = 0, n_fail = 0;
  int m_total, m_strb, m_cs, m_bad, m_ta, m_done2;
  logic [DW-1:0] m_rdata;

  xmem_async_ctrl u_xmem_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cs(req_cs), .req_addr(req_addr), .req_bank(req_bank),
    .req_be(req_be), .req_wdata(req_wdata), .cfg_rd_setup(cfg_rd_setup),
    .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold), .cfg_wr_setup(cfg_wr_setup),
    .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold), .cfg_turn(cfg_turn),
    .cfg_ext_wait(cfg_ext_wait), .cfg_sel_strobe(cfg_sel_strobe), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_bank(mem_bank), .mem_bmask_n(mem_bmask_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_wait_n(mem_wait_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int min1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic set_cfg(input int cs, input int s, input int st, input int h,
                         input int ta, input logic ew, input logic ss);
    cfg_rd_setup[cs*CW +: CW]  = CW'(s);
    cfg_rd_strobe[cs*CW +: CW] = CW'(st);
    cfg_rd_hold[cs*CW +: CW]   = CW'(h);
    cfg_wr_setup[cs*CW +: CW]  = CW'(s);
    cfg_wr_strobe[cs*CW +: CW] = CW'(st);
    cfg_wr_hold[cs*CW +: CW]   = CW'(h);
    cfg_turn[cs*CW +: CW]      = CW'(ta);
    cfg_ext_wait[cs]           = ew;
    cfg_sel_strobe[cs]         = ss;
  endtask

  // Called at a negedge while idle; returns at a negedge with req_ready high.
  task automatic run_access(input logic wr, input int cs, input logic [AW-1:0] a,
                            input logic [BW-1:0] bk, input logic [MW-1:0] be,
                            input logic [DW-1:0] wd, input int rel_k, input bit intrude);
    int c;
    bit done_seen;
    m_total = 0; m_strb = 0; m_cs = 0; m_bad = 0; m_ta = 0;
    req_write = wr; req_cs = IW'(cs); req_addr = a; req_bank = bk;
    req_be = be; req_wdata = wd; req_valid = 1'b1;
    done_seen = 1'b0;
    c = 0;
    while (!done_seen && c < 200) begin
      @(negedge clk);
      c++;
      if (c == 1) req_valid = 1'b0;
      if (intrude && c == 2) begin req_valid = 1'b1; req_addr = ~a; end
      if (intrude && c == 3) req_valid = 1'b0;
      mem_dq_in = 16'hA000 + c[15:0];
      if (wr ? !mem_we_n : !mem_oe_n) m_strb++;
      if (wr ? !mem_oe_n : !mem_we_n) m_bad++;
      if (!mem_cs_n[cs]) m_cs++;
      for (int j = 0; j < NCS; j++) if (j != cs && !mem_cs_n[j]) m_bad++;
      if (mem_addr != a || mem_bank != bk || mem_bmask_n != ~be) m_bad++;
      if (mem_dq_oe != wr) m_bad++;
      if (wr && mem_dq_out != wd) m_bad++;
      if (rel_k >= 0 && m_strb == rel_k && !mem_wait_n) mem_wait_n = 1'b1;
      if (rsp_done) begin done_seen = 1'b1; m_total = c; m_rdata = rsp_rdata; end
    end
    @(negedge clk);
    m_done2 = int'(rsp_done);
    while (!req_ready && m_ta < 40) begin
      m_ta++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_cs = '0; req_addr = '0;
    req_bank = '0; req_be = '0; req_wdata = '0; mem_dq_in = '0; mem_wait_n = 1'b1;
    for (int i = 0; i < NCS; i++) set_cfg(i, 1, 1, 1, 0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    // reset state
    chk("R11", "reset ready", int'(req_ready), 1);
    chk("R11", "reset cs_n", int'(mem_cs_n), 7);
    chk("R12", "reset strobes", int'({mem_oe_n, mem_we_n}), 3);
    chk("R3", "reset bmask_n", int'(mem_bmask_n), 3);
    chk("R9", "reset done", int'(rsp_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "idle dq_oe", int'(mem_dq_oe), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      int s, st;
      string tag;
      v = VEC[i];
      s = int'(v[32:29]); st = int'(v[28:25]);
      tag = v[35] ? "R2" : "R1";
      set_cfg(int'(v[34:33]), s, st, int'(v[24:21]), int'(v[20:17]), 1'b0, v[16]);
      run_access(v[35], int'(v[34:33]), AW'(32'h2A5A5 * (i + 1)), BW'(i),
                 MW'(i + 1), 16'h5A00 + 16'(i), -1, 1'b0);
      chk(tag, "total cycles", m_total, int'(v[15:10]));
      chk(tag, "strobe width", m_strb, int'(v[9:6]));
      chk(v[16] ? "R4" : "R4", "cs width", m_cs, int'(v[5:0]));
      chk(i >= 4 ? "R6" : "R3", "bus faults (R5)", m_bad, 0);
      chk("R10", "turnaround", m_ta, int'(v[20:17]));
      chk("R9", "done second cycle", m_done2, 0);
      if (!v[35]) chk("R9", "read data", int'(m_rdata), 32'hA000 + min1(s) + min1(st));
    end

    // extended wait, release after 4th strobe cycle
    set_cfg(0, 1, 2, 1, 0, 1'b1, 1'b0);
    mem_wait_n = 1'b0;
    repeat (3) @(negedge clk);
    run_access(1'b0, 0, 22'h012345, 2'd1, 2'b11, 16'h0, 4, 1'b0);
    chk("R7", "stretched strobe K=4", m_strb, 10);
    chk("R7", "stretched total", m_total, 12);
    chk("R9", "read data after wait", int'(m_rdata), 32'hA000 + 11);

    // extended wait, release on the last programmed strobe cycle
    mem_wait_n = 1'b0;
    repeat (3) @(negedge clk);
    run_access(1'b0, 0, 22'h0ABCDE, 2'd2, 2'b01, 16'h0, 2, 1'b0);
    chk("R7", "stretched strobe K=ST", m_strb, 8);
    chk("R9", "read data K=ST", int'(m_rdata), 32'hA000 + 9);

    // extended wait enabled, wait input high: no stretch
    run_access(1'b1, 0, 22'h00FFFF, 2'd0, 2'b10, 16'hC3C3, -1, 1'b0);
    chk("R7", "no stretch when released", m_strb, 2);

    // wait disabled: input ignored
    set_cfg(0, 1, 2, 1, 0, 1'b0, 1'b0);
    mem_wait_n = 1'b0;
    repeat (3) @(negedge clk);
    run_access(1'b0, 0, 22'h155555, 2'd3, 2'b11, 16'h0, -1, 1'b0);
    chk("R8", "wait ignored strobe", m_strb, 2);
    chk("R8", "wait ignored total", m_total, 4);
    mem_wait_n = 1'b1;

    // request while busy is not accepted
    set_cfg(1, 1, 2, 1, 2, 1'b0, 1'b0);
    run_access(1'b0, 1, 22'h2AAAAA, 2'd1, 2'b11, 16'h0, -1, 1'b1);
    chk("R11", "busy request bus faults", m_bad, 0);
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (mem_cs_n != '1 || !req_ready) extra++;
      end
      chk("R11", "no second access", extra, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule